// File: doc/BRIEF.md
# Fuse Key Image Encoder

This block turns a key parameter of selectable width into the fixed 256-bit image that a fuse programmer burns. A 2-bit coding selector picks one of three layouts. The first copies all 256 data bits unchanged. The second duplicates 128 data bits into both halves of the image. The third is a three-quarter-rate code: each run of six data bytes is followed by an XOR check byte and a position-weighted population-count byte. A reserve flag forces the three-quarter code whatever the selector says. When the image is bound for the third key slot, that flag also withholds one encoded group from programming.

Next to the image, the block produces a program mask with one bit per image bit. A 1 in the mask marks a bit that the fuse programmer may burn. The encoder takes one registered cycle. A request presented with `in_valid` high returns its image, its mask and `out_valid` on the following clock. With no request, the outputs hold their values.

Top module: `fkenc_top`

## Requirements
- R1: Without the reserve flag, selector values 2'b00 and 2'b11 make the image equal to `key_data`, and the mask is all ones.
- R2: With selector 2'b01, for each group i (0..3) and byte j (0..5), image bits [64i+8j+7:64i+8j] equal data bits [48i+8j+7:48i+8j].
- R3: With selector 2'b01, image byte 8i+6 (bits [64i+55:64i+48]) is the bitwise XOR of data bytes 6i..6i+5.
- R4: With selector 2'b01, image byte 8i+7 (bits [64i+63:64i+56]) is the sum over l=0..5 of (l+1) times the count of set bits in data byte 6i+l. Its maximum is 168 (all data bits set), and it never wraps.
- R5: With selector 2'b10 and no reserve flag, image bits [127:0] and [255:128] both equal data bits [127:0], and the mask is all ones.
- R6: Data bits above the used width have no effect on the image: bits [255:192] under the three-quarter code and bits [255:128] under the repeat layout.
- R7: When `force_qtr` is 1, the three-quarter code of R2 to R4 is used whatever the value of `scheme_sel`.
- R8: When `force_qtr` and `dest_third` are both 1, image bits [191:128] are 0, mask bits [191:128] are 0, and all other mask bits are 1. When `dest_third` is 0, the mask is all ones.
- R9: A request with `in_valid` high produces `out_valid` high on the next clock, together with the image and mask for that request's inputs.
- R10: A cycle with `in_valid` low gives `out_valid` low on the next clock and leaves the image and mask unchanged, whatever the data inputs do.
- R11: During reset, `out_valid`, `fuse_image` and `prog_mask` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| key_data | input | 256 | Key data word, low bits used first |
| scheme_sel | input | 2 | Coding selector: 00/11 plain, 01 three-quarter, 10 repeat |
| force_qtr | input | 1 | Reserve flag; forces the three-quarter code |
| dest_third | input | 1 | Image targets the third key slot |
| out_valid | output | 1 | Image and mask are fresh |
| fuse_image | output | 256 | Encoded fuse image |
| prog_mask | output | 256 | 1 where the image bit may be programmed |

## Verification
The bench tries the three-quarter code on several data patterns. All-zero data yields zero check bytes. All-ones data drives the weighted count to its 168 ceiling and cancels every XOR byte. A single set bit shows whether byte weights and group offsets land in the right place. Random words with random upper bits show that unused data has no effect. Every selector value is run both with and without the reserve flag and the third-slot target, which separates selector decoding from the forcing and masking logic. Idle cycles with changing data check that the outputs hold.

// File: rtl/fkenc_pkg.sv
package fkenc_pkg;

    localparam int BYTE_W = 8;
    localparam int POP_W  = $clog2(BYTE_W + 1);

    typedef enum logic [1:0] {
        SCH_PLAIN  = 2'd0,
        SCH_QTR    = 2'd1,
        SCH_REPEAT = 2'd2
    } scheme_e;

    function automatic logic [POP_W-1:0] popcnt_byte(input logic [BYTE_W-1:0] b);
        logic [POP_W-1:0] n;
        n = '0;
        for (int k = 0; k < BYTE_W; k++) begin
            n = n + POP_W'(b[k]);
        end
        return n;
    endfunction

endpackage

// File: rtl/fkenc_scheme_sel.sv
module fkenc_scheme_sel
    import fkenc_pkg::*;
(
    input  logic [1:0] scheme_sel,
    input  logic       force_qtr,
    output scheme_e    scheme
);

    always_comb begin
        if (force_qtr) begin
            scheme = SCH_QTR;
        end else begin
            unique case (scheme_sel)
                2'b01:   scheme = SCH_QTR;
                2'b10:   scheme = SCH_REPEAT;
                default: scheme = SCH_PLAIN;
            endcase
        end
    end

endmodule

// File: rtl/fkenc_group.sv
module fkenc_group
    import fkenc_pkg::*;
#(
    parameter int DATA_BYTES = 6,
    localparam int CODE_BYTES = DATA_BYTES + 2,
    localparam int IN_W       = DATA_BYTES * BYTE_W,
    localparam int OUT_W      = CODE_BYTES * BYTE_W
) (
    input  logic [IN_W-1:0]  grp_data,
    output logic [OUT_W-1:0] grp_code
);

    logic [BYTE_W-1:0] xor_byte;
    logic [BYTE_W-1:0] wsum_byte;

    for (genvar j = 0; j < DATA_BYTES; j++) begin : g_copy
        assign grp_code[j*BYTE_W +: BYTE_W] = grp_data[j*BYTE_W +: BYTE_W];
    end

    always_comb begin
        xor_byte  = '0;
        wsum_byte = '0;
        for (int l = 0; l < DATA_BYTES; l++) begin
            xor_byte  = xor_byte ^ grp_data[l*BYTE_W +: BYTE_W];
            wsum_byte = wsum_byte
                      + BYTE_W'((l + 1) * int'(popcnt_byte(grp_data[l*BYTE_W +: BYTE_W])));
        end
    end

    assign grp_code[DATA_BYTES*BYTE_W +: BYTE_W]     = xor_byte;
    assign grp_code[(DATA_BYTES+1)*BYTE_W +: BYTE_W] = wsum_byte;

endmodule

// File: rtl/fkenc_top.sv
module fkenc_top
    import fkenc_pkg::*;
#(
    parameter int GROUPS     = 4,
    parameter int DATA_BYTES = 6,
    parameter int RSV_GROUP  = 2,
    localparam int GRP_IN_W  = DATA_BYTES * BYTE_W,
    localparam int GRP_OUT_W = (DATA_BYTES + 2) * BYTE_W,
    localparam int IMG_W     = GROUPS * GRP_OUT_W,
    localparam int HALF_W    = IMG_W / 2,
    localparam int RSV_LO    = RSV_GROUP * GRP_OUT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [IMG_W-1:0] key_data,
    input  logic [1:0]       scheme_sel,
    input  logic             force_qtr,
    input  logic             dest_third,
    output logic             out_valid,
    output logic [IMG_W-1:0] fuse_image,
    output logic [IMG_W-1:0] prog_mask
);

    typedef struct packed {
        logic             valid;
        logic [IMG_W-1:0] image;
        logic [IMG_W-1:0] mask;
    } state_t;

    state_t  st_d, st_q;
    scheme_e scheme;
    logic [IMG_W-1:0] qtr_img;

    fkenc_scheme_sel u_sel (
        .scheme_sel (scheme_sel),
        .force_qtr  (force_qtr),
        .scheme     (scheme)
    );

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        fkenc_group #(.DATA_BYTES(DATA_BYTES)) u_grp (
            .grp_data (key_data[g*GRP_IN_W +: GRP_IN_W]),
            .grp_code (qtr_img[g*GRP_OUT_W +: GRP_OUT_W])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.mask = '1;
            unique case (scheme)
                SCH_QTR:    st_d.image = qtr_img;
                SCH_REPEAT: st_d.image = {key_data[HALF_W-1:0], key_data[HALF_W-1:0]};
                default:    st_d.image = key_data;
            endcase
            if (force_qtr && dest_third) begin
                st_d.image[RSV_LO +: GRP_OUT_W] = '0;
                st_d.mask[RSV_LO +: GRP_OUT_W]  = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid  = st_q.valid;
    assign fuse_image = st_q.image;
    assign prog_mask  = st_q.mask;

    // R9: a request is answered on the next clock
    p_valid_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R10: idle cycles keep the outputs
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(fuse_image) && $stable(prog_mask)));

    // R1: plain layout passes data through
    p_plain_copy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !force_qtr && (scheme_sel == 2'b00 || scheme_sel == 2'b11))
        |=> (fuse_image == $past(key_data) && prog_mask == '1));

    // R5: repeat layout duplicates the low half
    p_repeat_halves_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !force_qtr && scheme_sel == 2'b10)
        |=> (fuse_image[IMG_W-1:HALF_W] == fuse_image[HALF_W-1:0]));

    // R8: reserved group withheld for the third slot
    p_rsv_blank_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && force_qtr && dest_third)
        |=> (fuse_image[RSV_LO +: GRP_OUT_W] == '0 && prog_mask[RSV_LO +: GRP_OUT_W] == '0));

endmodule

// File: tb/sim_fkenc_top.sv
`timescale 1ns/1ps
module sim_fkenc_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [255:0] key_data = '0;
    logic [1:0]   scheme_sel = 2'b00;
    logic         force_qtr = 1'b0;
    logic         dest_third = 1'b0;
    logic         out_valid;
    logic [255:0] fuse_image;
    logic [255:0] prog_mask;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    fkenc_top u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .key_data(key_data),
        .scheme_sel(scheme_sel), .force_qtr(force_qtr), .dest_third(dest_third),
        .out_valid(out_valid), .fuse_image(fuse_image), .prog_mask(prog_mask)
    );

    function automatic logic [255:0] exp_image(logic [255:0] d, logic [1:0] s, logic r, logic t);
        logic [255:0] e;
        logic [7:0]   x;
        int           w;
        e = '0;
        if (r || s == 2'b01) begin
            for (int i = 0; i < 4; i++) begin
                x = '0;
                w = 0;
                for (int k = 0; k < 48; k++) begin
                    e[64*i + k] = d[48*i + k];
                    x[k % 8] = x[k % 8] ^ d[48*i + k];
                    w = w + (k / 8 + 1) * int'(d[48*i + k]);
                end
                e[64*i + 48 +: 8] = x;
                e[64*i + 56 +: 8] = w[7:0];
            end
            if (r && t) e[191:128] = '0;
        end else if (s == 2'b10) begin
            e = {d[127:0], d[127:0]};
        end else begin
            e = d;
        end
        return e;
    endfunction

    function automatic logic [255:0] exp_mask(logic r, logic t);
        logic [255:0] m;
        m = '1;
        if (r && t) m[191:128] = '0;
        return m;
    endfunction

    task automatic check_vec(string tag, logic [255:0] act, logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic check_bit(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
        end
    endtask

    // drive at a falling edge, check at the next falling edge
    task automatic run_req(string tag, logic [255:0] d, logic [1:0] s, logic r, logic t);
        key_data = d; scheme_sel = s; force_qtr = r; dest_third = t; in_valid = 1'b1;
        @(negedge clk);
        check_bit({tag, " R9 valid"}, out_valid, 1'b1);
        check_vec({tag, " image"}, fuse_image, exp_image(d, s, r, t));
        check_vec({tag, " R8 mask"}, prog_mask, exp_mask(r, t));
    endtask

    function automatic logic [255:0] rnd256();
        logic [255:0] v;
        for (int i = 0; i < 8; i++) v[32*i +: 32] = $urandom;
        return v;
    endfunction

    initial begin
        #1_000_000;
        failures++;
        $display("FAIL R9 watchdog act=hung exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [255:0] d, held_img, held_mask;
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_bit("R11 valid", out_valid, 1'b0);
        check_vec("R11 image", fuse_image, '0);
        check_vec("R11 mask", prog_mask, '0);
        rst_n = 1'b1;

        run_req("R1 plain00", rnd256(), 2'b00, 1'b0, 1'b0);
        run_req("R1 plain11", rnd256(), 2'b11, 1'b0, 1'b1);
        run_req("R5 repeat", rnd256(), 2'b10, 1'b0, 1'b0);
        run_req("R2 R3 R4 zeros", '0, 2'b01, 1'b0, 1'b0);
        run_req("R4 ones max168", '1, 2'b01, 1'b0, 1'b0);
        d = '0; d[47] = 1'b1;
        run_req("R4 weight byte5", d, 2'b01, 1'b0, 1'b0);
        d = '0; d[48] = 1'b1;
        run_req("R2 group1 start", d, 2'b01, 1'b0, 1'b0);
        d = '0; d[255:192] = '1;
        run_req("R6 qtr upper", d, 2'b01, 1'b0, 1'b0);
        d = '0; d[255:128] = '1;
        run_req("R6 repeat upper", d, 2'b10, 1'b0, 1'b0);
        run_req("R7 force sel00", rnd256(), 2'b00, 1'b1, 1'b0);
        run_req("R7 force sel10", rnd256(), 2'b10, 1'b1, 1'b0);
        run_req("R8 third slot", '1, 2'b11, 1'b1, 1'b1);
        run_req("R8 plain third", rnd256(), 2'b00, 1'b0, 1'b1);

        // R10: idle cycles with moving inputs
        held_img = fuse_image;
        held_mask = prog_mask;
        for (int n = 0; n < 4; n++) begin
            in_valid = 1'b0;
            key_data = rnd256(); scheme_sel = 2'(n); force_qtr = 1'b0; dest_third = 1'b0;
            @(negedge clk);
            check_bit("R10 valid low", out_valid, 1'b0);
            check_vec("R10 image held", fuse_image, held_img);
            check_vec("R10 mask held", prog_mask, held_mask);
        end

        for (int n = 0; n < 300; n++) begin
            logic [1:0] s;
            logic r, t;
            s = 2'($urandom);
            r = ($urandom % 4) == 0;
            t = 1'($urandom);
            run_req("R2 R3 R4 R5 random", rnd256(), s, r, t);
        end

        in_valid = 1'b0;
        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule